// File: doc/BRIEF.md
# Serial Glitch-Free Clock Freeze Controller

This block lets a host stop and restart individual clock outputs through a two-wire serial link made of a freeze clock and a freeze data line. A frame opens with a low start bit and carries one enable bit for each gated output. The receiver collects the whole frame in a staging register. It copies all the bits into the live enable register together, on one rising edge of the freeze clock.

Each output clock has its own gate. The live enable bit passes through a two-flop synchroniser clocked by that output's ungated clock. The gate register itself loads only on that clock's falling edge. A frozen output therefore stops low at the end of a complete high phase, and a released output starts with a complete high phase. No shortened pulse appears on any output. A master reset releases every output and puts the receiver back into the wait-for-start state.

Top module: `clk_frz_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, until a frame commits, every enable is 1. Every gated output follows its ungated clock, and the receiver waits for a start bit.
- R2: A frame is a 0 start bit followed by NUM_OUT data bits, all sampled on rising edges of the freeze clock. The k-th data bit after the start bit (k from 0) controls output k. A bit value of 0 freezes that output and 1 lets it run.
- R3: The enables stay unchanged while a frame is being shifted in. The new settings commit on the first rising freeze-clock edge after the last data bit.
- R4: If the bit sampled on the commit edge is 0, it acts as the start bit of the next frame, so frames can run back to back.
- R5: While the receiver is waiting for a start bit, any number of 1 bits leave both the receiver state and the enables unchanged.
- R6: A frozen output goes low only when its ungated clock falls and then stays low. No high time is shorter than half the ungated period.
- R7: A released output goes high only when its ungated clock rises. No low time is shorter than half the ungated period.
- R8: A committed setting appears on an output within four periods of that output's ungated clock after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| frz_clk_i | input | 1 | Serial freeze clock; data is sampled on its rising edge |
| rst_i | input | 1 | Master reset, active high, synchronous in every domain |
| frz_data_i | input | 1 | Serial freeze data, NRZ |
| bank_clk_i | input | NUM_OUT | Ungated bank clocks, one for each output |
| gated_clk_o | output | NUM_OUT | Gated clocks, frozen low when disabled |

## Verification
The enables commit on the rising freeze-clock edge that follows the last data bit. The bench drives the freeze clock itself, so it can stop just before that edge and measure the outputs still in their old state. After the commit edge, a setting needs two rising edges and one falling edge of the output's own clock to reach the output. The bench waits four periods of its slowest clock before it counts rising edges over a fixed window. Edge monitors run for the whole test and record every gated high or low time that is shorter than half of the ungated period.

// File: rtl/clk_frz_pkg.sv
package clk_frz_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_SHIFT  = 2'd1,
    RX_COMMIT = 2'd2
  } rx_state_t;
endpackage

// File: rtl/clk_frz_rx.sv
module clk_frz_rx
  import clk_frz_pkg::*;
#(
  parameter int NUM_OUT = 12
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               din_i,
  output logic [NUM_OUT-1:0] en_o,
  output rx_state_t          state_o
);
  localparam int CW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_OUT - 1);

  rx_state_t          state_q;
  logic [CW-1:0]      cnt_q;
  logic [NUM_OUT-1:0] stage_q;
  logic [NUM_OUT-1:0] en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      stage_q <= '1;
      en_q    <= '1;
    end else begin
      case (state_q)
        RX_IDLE: begin
          if (!din_i) begin
            state_q <= RX_SHIFT;
            cnt_q   <= '0;
          end
        end
        RX_SHIFT: begin
          stage_q[cnt_q] <= din_i;
          if (cnt_q == LAST) begin
            state_q <= RX_COMMIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_COMMIT: begin
          en_q <= stage_q;
          cnt_q <= '0;
          if (!din_i) begin
            state_q <= RX_SHIFT;
          end else begin
            state_q <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign en_o    = en_q;
  assign state_o = state_q;
endmodule

// File: rtl/clk_frz_gate.sv
module clk_frz_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic gate_o,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   gate_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
    end
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      gate_q <= 1'b1;
    end else begin
      gate_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign gate_o = gate_q;
  assign clk_o  = clk_i & gate_q;
endmodule

// File: rtl/clk_frz_ctrl.sv
module clk_frz_ctrl
  import clk_frz_pkg::*;
#(
  parameter int NUM_OUT     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               frz_clk_i,
  input  logic               rst_i,
  input  logic               frz_data_i,
  input  logic [NUM_OUT-1:0] bank_clk_i,
  output logic [NUM_OUT-1:0] gated_clk_o
);
  logic [NUM_OUT-1:0] en_vec;
  logic [NUM_OUT-1:0] gate_vec;
  rx_state_t          rx_state;

  clk_frz_rx #(.NUM_OUT(NUM_OUT)) rx_i (
    .clk_i   (frz_clk_i),
    .rst_i   (rst_i),
    .din_i   (frz_data_i),
    .en_o    (en_vec),
    .state_o (rx_state)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    clk_frz_gate #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
      .clk_i  (bank_clk_i[g]),
      .rst_i  (rst_i),
      .en_i   (en_vec[g]),
      .gate_o (gate_vec[g]),
      .clk_o  (gated_clk_o[g])
    );
  end
endmodule

// File: rtl/clk_frz_ctrl_chk.sv
module clk_frz_ctrl_chk
  import clk_frz_pkg::*;
#(
  parameter int NUM_OUT = 12
) (
  input logic               frz_clk_i,
  input logic               rst_i,
  input logic               frz_data_i,
  input logic [NUM_OUT-1:0] bank_clk_i,
  input logic [NUM_OUT-1:0] en_vec,
  input logic [NUM_OUT-1:0] gate_vec,
  input rx_state_t          rx_state
);
  // R1: reset forces every enable to the running value
  assert_reset_unfrozen_R1: assert property (@(posedge frz_clk_i)
    rst_i |=> (en_vec == {NUM_OUT{1'b1}}));

  // R3: enables move only on the commit edge
  assert_commit_only_R3: assert property (@(posedge frz_clk_i) disable iff (rst_i)
    !$stable(en_vec) |-> ($past(rx_state) == RX_COMMIT));

  // R5: idle 1 bits leave the receiver and enables alone
  assert_idle_hold_R5: assert property (@(posedge frz_clk_i) disable iff (rst_i)
    (rx_state == RX_IDLE && frz_data_i) |=> (rx_state == RX_IDLE && $stable(en_vec)));

  // R6 and R7: a gate may switch only while its clock is low
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gchk
    always @(gate_vec[g]) begin
      if (!rst_i) begin
        assert_gate_low_R6: assert (bank_clk_i[g] == 1'b0);
      end
    end
  end
endmodule

bind clk_frz_ctrl clk_frz_ctrl_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .frz_clk_i  (frz_clk_i),
  .rst_i      (rst_i),
  .frz_data_i (frz_data_i),
  .bank_clk_i (bank_clk_i),
  .en_vec     (en_vec),
  .gate_vec   (gate_vec),
  .rx_state   (rx_state)
);

// File: tb/clk_frz_ctrl_tb.sv
`timescale 1ns/1ps
module clk_frz_ctrl_tb_top;
  localparam int N = 12;
  localparam int SETTLE = 120;
  localparam int WINDOW = 400;

  logic         frz_clk;
  logic         rst;
  logic         frz_data;
  logic [N-1:0] bclk;
  logic [N-1:0] gclk;

  int      checks = 0;
  int      errors = 0;
  int      rises [N];
  int      runt  [N];
  realtime tlast [N];

  clk_frz_ctrl #(.NUM_OUT(N)) dut_i (
    .frz_clk_i   (frz_clk),
    .rst_i       (rst),
    .frz_data_i  (frz_data),
    .bank_clk_i  (bclk),
    .gated_clk_o (gclk)
  );

  for (genvar g = 0; g < N; g++) begin : g_clk
    localparam int HP = 4 + g;
    initial begin
      bclk[g] = 1'b0;
      rises[g] = 0;
      runt[g] = 0;
      tlast[g] = 0.0;
      forever #(HP) bclk[g] = ~bclk[g];
    end
    always @(gclk[g]) begin
      if (!rst && tlast[g] > 0.0 && ($realtime - tlast[g]) < (real'(HP) - 0.01))
        runt[g] = runt[g] + 1;
      tlast[g] = $realtime;
    end
    always @(posedge gclk[g]) rises[g] = rises[g] + 1;
  end

  task automatic send_bit(input logic b);
    frz_data = b;
    #4 frz_clk = 1'b1;
    #4 frz_clk = 1'b0;
  endtask

  task automatic send_data(input logic [N-1:0] m);
    for (int k = 0; k < N; k++) send_bit(m[k]);
  endtask

  task automatic check_mask(input logic [N-1:0] m, input string tag);
    int snap [N];
    #SETTLE;
    for (int i = 0; i < N; i++) snap[i] = rises[i];
    #WINDOW;
    for (int i = 0; i < N; i++) begin
      logic run;
      run = (rises[i] - snap[i]) > 0;
      checks++;
      if (run !== m[i] || (!m[i] && gclk[i] !== 1'b0)) begin
        errors++;
        $display("FAIL %s out%0d running=%0b level=%0b expected running=%0b",
                 tag, i, run, gclk[i], m[i]);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int k = 0; k < 3; k++) send_bit(1'b1);
    #100;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_mask('1, "R1 reset all running");
  endtask

  task automatic t_frame();
    send_bit(1'b0);
    send_data(12'hA5A);
    send_bit(1'b1);
    check_mask(12'hA5A, "R2 frame A5A");
  endtask

  task automatic t_hold();
    send_bit(1'b0);
    send_data(12'h000);
    check_mask(12'hA5A, "R3 no change before commit edge");
    send_bit(1'b1);
    check_mask(12'h000, "R3 commit R8 latency");
  endtask

  task automatic t_b2b();
    send_bit(1'b0);
    send_data(12'hF0F);
    send_bit(1'b0);
    check_mask(12'hF0F, "R4 first frame of pair");
    send_data(12'h3C3);
    send_bit(1'b1);
    check_mask(12'h3C3, "R4 back-to-back second frame");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    check_mask(12'h3C3, "R5 idle ones ignored");
    send_bit(1'b0);
    send_data(12'hFDF);
    send_bit(1'b1);
    check_mask(12'hFDF, "R2 R6 single output frozen");
    send_bit(1'b0);
    send_data(12'hFFF);
    send_bit(1'b1);
    check_mask(12'hFFF, "R7 single output released");
  endtask

  task automatic t_reset_release();
    send_bit(1'b0);
    send_data(12'h000);
    send_bit(1'b1);
    check_mask(12'h000, "R2 all frozen");
    t_reset();
  endtask

  task automatic t_runts();
    for (int i = 0; i < N; i++) begin
      checks++;
      if (runt[i] != 0) begin
        errors++;
        $display("FAIL R6 R7 out%0d short pulses=%0d expected 0", i, runt[i]);
      end
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    frz_clk = 1'b0;
    frz_data = 1'b1;
    rst = 1'b1;
    t_reset();
    t_frame();
    t_hold();
    t_b2b();
    t_idle();
    t_reset_release();
    t_runts();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule